// File: doc/BRIEF.md
# Pin Attribute Control Bank

This block keeps one 32-bit control word for each pin of a port. The word's lower half carries the pad attributes that the pad ring consumes: pull mode, slew rate, passive input filter, open-drain output, high drive strength, a 3-bit function select and a lock bit. The upper half carries a 4-bit event-configuration field that the block stores and forwards. Software reaches each word through a simple register bus. The write is synchronous and the read is combinational on the address.

Two wide write ports let software set up many pins in one cycle. Each port covers one half of the pins. It carries a pin mask in bits 31:16 and a 16-bit attribute value in bits 15:0, and it loads that value into the lower half of every selected pin. Once a pin's lock bit is set, the lower half of that pin is frozen until reset, whichever path the write comes from. The block decodes every word into per-pin attribute outputs for the pads.

Top module: `pin_ctl_bank`

## Requirements
- R1: After reset every control word reads 0, and all decoded outputs are 0 except `pad_off`, which is 1 for every pin because its function select is 0.
- R2: A bus write to pin p (`bus_addr` = p) stores only the writable bits: 0, 1, 2, 4, 5, 6, 8 to 10, 15 and 16 to 19. All other bits read 0. `bus_rdata` shows the word selected by `bus_addr` in the same cycle.
- R3: Bits 1:0 select the pull mode. Code 2 gives pull-down (`pad_pull_en`=1, `pad_pull_up`=0), code 3 gives pull-up (both 1), and codes 0 and 1 give no pull (both 0).
- R4: `pad_slew_slow` follows bit 2, `pad_filt_en` follows bit 4, `pad_od_en` follows bit 5 and `pad_drv_hi` follows bit 6.
- R5: `pad_mux` shows bits 10:8. `pad_off` is 1 when that value is 0 (disabled or analog use), and `pad_gpio` is 1 when it is 1.
- R6: A low-group write (`glo_we`) loads `glo_wdata[15:0]` (writable bits only) into bits 15:0 of each pin i in 0..15 whose mask bit `glo_wdata[16+i]` is 1. Other pins and all upper halves keep their values.
- R7: A high-group write (`ghi_we`) does the same for pins 16..31, using mask bit `ghi_wdata[16+i-16]` for pin i.
- R8: Once bit 15 (lock) of a pin is 1, bits 15:0 of that pin ignore bus writes and group writes, including writes of 0 to the lock bit, until reset.
- R9: A bus write to a locked pin still updates that pin's event field in bits 19:16, and `pad_evt_cfg` follows it.
- R10: If a bus write and a group write select the same unlocked pin in one cycle, the bus write's lower half is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Bus write strobe for one pin word |
| bus_addr | input | 5 | Pin index for write and read |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Word of the addressed pin |
| glo_we | input | 1 | Low-group write strobe (pins 0..15) |
| glo_wdata | input | 32 | Mask in 31:16, attribute value in 15:0 |
| ghi_we | input | 1 | High-group write strobe (pins 16..31) |
| ghi_wdata | input | 32 | Mask in 31:16, attribute value in 15:0 |
| pad_pull_en | output | 32 | Pull resistor enabled, per pin |
| pad_pull_up | output | 32 | Pull direction is up, per pin |
| pad_slew_slow | output | 32 | Slow slew selected, per pin |
| pad_filt_en | output | 32 | Passive filter enabled, per pin |
| pad_od_en | output | 32 | Open drain enabled, per pin |
| pad_drv_hi | output | 32 | High drive strength, per pin |
| pad_mux | output | 96 | 3-bit function select, per pin |
| pad_off | output | 32 | Function select is 0 (disabled or analog) |
| pad_gpio | output | 32 | Function select is 1 (GPIO) |
| pad_locked | output | 32 | Lower half frozen, per pin |
| pad_evt_cfg | output | 128 | 4-bit event field, per pin |

## Verification
The hardest case to reach is a single cycle in which a bus write, a group write and a lock all meet on the same pin. The lock must hold against both paths while the bus write still lands in the upper half. Directed sequences lock a pin and then strike it from each path, and from both at once. The random phase drives the bus and both group ports in the same cycles with wide masks, and sets the lock bit only rarely. Locked and unlocked pins therefore stay mixed for thousands of cycles. A final reset shows that locks are cleared only by reset.

// File: rtl/pcr_pkg.sv
// Shared constants for the pin attribute control bank.
// Assumes 32-bit control words with the attribute half in bits 15:0.
package pcr_pkg;
    localparam int REG_W   = 32;
    localparam int ATTR_W  = 16;
    localparam int MUX_W   = 3;
    localparam int EVT_W   = 4;
    localparam int MUX_LSB = 8;
    localparam int EVT_LSB = 16;
    localparam int LOCK_B  = 15;
    localparam int SLEW_B  = 2;
    localparam int FILT_B  = 4;
    localparam int ODE_B   = 5;
    localparam int DRV_B   = 6;
    // writable bits of the attribute half
    localparam logic [ATTR_W-1:0] LO_WMASK = 16'h8777;
    // writable bits of the upper half (event field)
    localparam logic [ATTR_W-1:0] HI_WMASK = 16'h000F;

    typedef enum logic [1:0] {
        PULL_NONE = 2'd0,
        PULL_RSVD = 2'd1,
        PULL_DOWN = 2'd2,
        PULL_UP   = 2'd3
    } pull_mode_e;
endpackage

// File: rtl/pcr_glb_route.sv
// Routes the two group write ports to per-pin hit strobes and values.
// Assumes NUM_PINS is even and at most 32, so each half fits a 16-bit mask.
module pcr_glb_route
    import pcr_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lo_we,
    input  logic [REG_W-1:0]           lo_wdata,
    input  logic                       hi_we,
    input  logic [REG_W-1:0]           hi_wdata,
    output logic [NUM_PINS-1:0]        hit,
    output logic [NUM_PINS*ATTR_W-1:0] val
);
    localparam int GRP = NUM_PINS / 2;

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_route
            if (i < GRP) begin : g_lo
                // low group: mask bit 16+i, value from the low port
                assign hit[i] = lo_we & lo_wdata[ATTR_W + i];
                assign val[i*ATTR_W +: ATTR_W] = lo_wdata[ATTR_W-1:0];
            end else begin : g_hi
                // high group: mask bit 16+(i-GRP), value from the high port
                assign hit[i] = hi_we & hi_wdata[ATTR_W + i - GRP];
                assign val[i*ATTR_W +: ATTR_W] = hi_wdata[ATTR_W-1:0];
            end
        end
    endgenerate

    AST_LO_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_we |-> (hit[GRP-1:0] == '0)); // R6
    AST_HI_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_we |-> (hit[NUM_PINS-1:GRP] == '0)); // R7
endmodule

// File: rtl/pcr_pin_reg.sv
// One pin's control word: bus write, group write and a sticky lock.
// Assumes at most one bus write and one group write per cycle for this pin;
// the bus write wins on the attribute half.
module pcr_pin_reg
    import pcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_we,
    input  logic [REG_W-1:0]  pin_wdata,
    input  logic              glb_we,
    input  logic [ATTR_W-1:0] glb_val,
    output logic [REG_W-1:0]  q
);
    logic              locked;
    logic [ATTR_W-1:0] lo_nxt;
    logic [ATTR_W-1:0] hi_nxt;

    assign locked = q[LOCK_B];

    // next-state selection for both halves
    always_comb begin
        lo_nxt = q[ATTR_W-1:0];
        hi_nxt = q[REG_W-1:ATTR_W];
        if (pin_we)
            hi_nxt = pin_wdata[REG_W-1:ATTR_W] & HI_WMASK;
        if (!locked) begin
            if (pin_we)
                lo_nxt = pin_wdata[ATTR_W-1:0] & LO_WMASK;
            else if (glb_we)
                lo_nxt = glb_val & LO_WMASK;
        end
    end

    // word storage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= {hi_nxt, lo_nxt};
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q[LOCK_B] |=> q[LOCK_B]); // R8
    AST_LOCKED_LO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        q[LOCK_B] |=> $stable(q[ATTR_W-1:0])); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~{HI_WMASK, LO_WMASK}) == '0); // R2
    AST_BUS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_we && !q[LOCK_B]) |=> q[ATTR_W-1:0] == ($past(pin_wdata[ATTR_W-1:0]) & LO_WMASK)); // R10
    AST_GLB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_we && !pin_we && !q[LOCK_B]) |=> q[ATTR_W-1:0] == ($past(glb_val) & LO_WMASK)); // R6
    AST_EVT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_we |=> q[REG_W-1:ATTR_W] == ($past(pin_wdata[REG_W-1:ATTR_W]) & HI_WMASK)); // R9
endmodule

// File: rtl/pcr_attr_dec.sv
// Decodes one control word into pad attribute signals.
// Purely combinational; assumes reserved bits are already zero.
module pcr_attr_dec
    import pcr_pkg::*;
(
    input  logic [REG_W-1:0] word,
    output logic             pull_en,
    output logic             pull_up,
    output logic             slew_slow,
    output logic             filt_en,
    output logic             od_en,
    output logic             drv_hi,
    output logic [MUX_W-1:0] mux,
    output logic             off,
    output logic             gpio,
    output logic             locked,
    output logic [EVT_W-1:0] evt
);
    pull_mode_e pmode;

    // attribute field decode
    always_comb begin
        pmode     = pull_mode_e'(word[1:0]);
        pull_en   = (pmode == PULL_DOWN) || (pmode == PULL_UP);
        pull_up   = (pmode == PULL_UP);
        slew_slow = word[SLEW_B];
        filt_en   = word[FILT_B];
        od_en     = word[ODE_B];
        drv_hi    = word[DRV_B];
        mux       = word[MUX_LSB +: MUX_W];
        off       = (mux == MUX_W'(0));
        gpio      = (mux == MUX_W'(1));
        locked    = word[LOCK_B];
        evt       = word[EVT_LSB +: EVT_W];
    end
endmodule

// File: rtl/pin_ctl_bank.sv
// Pin attribute control bank: per-pin words, two group write ports,
// sticky per-pin lock and decoded pad outputs.
// Assumes NUM_PINS even and at most 32; reads are combinational on bus_addr.
module pin_ctl_bank
    import pcr_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int AW       = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [AW-1:0]             bus_addr,
    input  logic [REG_W-1:0]          bus_wdata,
    output logic [REG_W-1:0]          bus_rdata,
    input  logic                      glo_we,
    input  logic [REG_W-1:0]          glo_wdata,
    input  logic                      ghi_we,
    input  logic [REG_W-1:0]          ghi_wdata,
    output logic [NUM_PINS-1:0]       pad_pull_en,
    output logic [NUM_PINS-1:0]       pad_pull_up,
    output logic [NUM_PINS-1:0]       pad_slew_slow,
    output logic [NUM_PINS-1:0]       pad_filt_en,
    output logic [NUM_PINS-1:0]       pad_od_en,
    output logic [NUM_PINS-1:0]       pad_drv_hi,
    output logic [NUM_PINS*MUX_W-1:0] pad_mux,
    output logic [NUM_PINS-1:0]       pad_off,
    output logic [NUM_PINS-1:0]       pad_gpio,
    output logic [NUM_PINS-1:0]       pad_locked,
    output logic [NUM_PINS*EVT_W-1:0] pad_evt_cfg
);
    logic [NUM_PINS-1:0]        glb_hit;
    logic [NUM_PINS*ATTR_W-1:0] glb_val;
    logic [REG_W-1:0]           words [NUM_PINS];

    pcr_glb_route #(.NUM_PINS(NUM_PINS)) route_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_we    (glo_we),
        .lo_wdata (glo_wdata),
        .hi_we    (ghi_we),
        .hi_wdata (ghi_wdata),
        .hit      (glb_hit),
        .val      (glb_val)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_pin
            logic sel;
            assign sel = bus_we && (bus_addr == AW'(i));

            pcr_pin_reg reg_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_we    (sel),
                .pin_wdata (bus_wdata),
                .glb_we    (glb_hit[i]),
                .glb_val   (glb_val[i*ATTR_W +: ATTR_W]),
                .q         (words[i])
            );

            pcr_attr_dec dec_i (
                .word      (words[i]),
                .pull_en   (pad_pull_en[i]),
                .pull_up   (pad_pull_up[i]),
                .slew_slow (pad_slew_slow[i]),
                .filt_en   (pad_filt_en[i]),
                .od_en     (pad_od_en[i]),
                .drv_hi    (pad_drv_hi[i]),
                .mux       (pad_mux[i*MUX_W +: MUX_W]),
                .off       (pad_off[i]),
                .gpio      (pad_gpio[i]),
                .locked    (pad_locked[i]),
                .evt       (pad_evt_cfg[i*EVT_W +: EVT_W])
            );
        end
    endgenerate

    // combinational read of the addressed word
    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) < NUM_PINS) bus_rdata = words[bus_addr];
    end

    AST_PULL_UP_IMPLIES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_up & ~pad_pull_en) == '0); // R3
    AST_OFF_GPIO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_off & pad_gpio) == '0); // R5
endmodule

// File: tb/pin_ctl_bank_tb_top.sv
module pin_ctl_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        glo_we, ghi_we;
    logic [31:0] glo_wdata, ghi_wdata;
    logic [N-1:0] pad_pull_en, pad_pull_up, pad_slew_slow, pad_filt_en;
    logic [N-1:0] pad_od_en, pad_drv_hi, pad_off, pad_gpio, pad_locked;
    logic [N*3-1:0] pad_mux;
    logic [N*4-1:0] pad_evt_cfg;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] model [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_ctl_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glo_we(glo_we), .glo_wdata(glo_wdata), .ghi_we(ghi_we), .ghi_wdata(ghi_wdata),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up), .pad_slew_slow(pad_slew_slow),
        .pad_filt_en(pad_filt_en), .pad_od_en(pad_od_en), .pad_drv_hi(pad_drv_hi),
        .pad_mux(pad_mux), .pad_off(pad_off), .pad_gpio(pad_gpio),
        .pad_locked(pad_locked), .pad_evt_cfg(pad_evt_cfg)
    );

    // expected next word from the requirements
    function automatic logic [31:0] next_word(logic [31:0] old, logic pw, logic [31:0] pwd,
                                              logic gw, logic [15:0] gv);
        logic [15:0] lo = old[15:0];
        logic [15:0] hi = old[31:16];
        if (pw) hi = pwd[31:16] & 16'h000F;
        if (!old[15]) begin
            if (pw)      lo = pwd[15:0] & 16'h8777;
            else if (gw) lo = gv & 16'h8777;
        end
        return {hi, lo};
    endfunction

    // expected decoded outputs for one word, packed in a fixed order
    function automatic logic [18:0] exp_dec(logic [31:0] w);
        logic [2:0] m = w[10:8];
        return {w[1], w[1] & w[0], w[2], w[4], w[5], w[6], m,
                m == 3'd0, m == 3'd1, w[15], w[19:16]};
    endfunction

    function automatic logic [18:0] act_dec(int p);
        logic [2:0] m = pad_mux[p*3 +: 3];
        return {pad_pull_en[p], pad_pull_up[p], pad_slew_slow[p], pad_filt_en[p],
                pad_od_en[p], pad_drv_hi[p], m, pad_off[p], pad_gpio[p],
                pad_locked[p], pad_evt_cfg[p*4 +: 4]};
    endfunction

    task automatic chk(string tag, int p, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s pin %0d: actual %h expected %h", tag, p, act, exp);
        end
    endtask

    task automatic check_pin(string tag, int p);
        bus_addr = 5'(p);
        #1;
        chk(tag, p, bus_rdata, model[p]);
        chk(tag, p, {13'd0, act_dec(p)}, {13'd0, exp_dec(model[p])});
    endtask

    task automatic check_all(string tag);
        for (int p = 0; p < N; p++) check_pin(tag, p);
    endtask

    // one clock with the given strobes; model updated from the same inputs
    task automatic drive(logic pw, int pa, logic [31:0] pwd,
                         logic lw, logic [31:0] ld, logic hw, logic [31:0] hd);
        @(negedge clk);
        bus_we = pw; bus_addr = 5'(pa); bus_wdata = pwd;
        glo_we = lw; glo_wdata = ld; ghi_we = hw; ghi_wdata = hd;
        @(posedge clk);
        for (int p = 0; p < N; p++) begin
            logic gw = (p < 16) ? (lw & ld[16+p]) : (hw & hd[p]);
            logic [15:0] gv = (p < 16) ? ld[15:0] : hd[15:0];
            model[p] = next_word(model[p], pw && (pa == p), pwd, gw, gv);
        end
        #1;
        bus_we = 1'b0; glo_we = 1'b0; ghi_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < N; p++) model[p] = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        bus_we = 0; bus_addr = 0; bus_wdata = 0;
        glo_we = 0; glo_wdata = 0; ghi_we = 0; ghi_wdata = 0;
        rst_n = 1'b0;
        do_reset();
        check_all("R1");

        // R2: reserved bits dropped, writable bits kept
        drive(1, 3, 32'hFFFF_7FFF, 0, 0, 0, 0);
        check_pin("R2", 3);
        // R3: all four pull codes
        for (int c = 0; c < 4; c++) begin
            drive(1, 4 + c, 32'(c), 0, 0, 0, 0);
            check_pin("R3", 4 + c);
        end
        // R4: feature bits one at a time
        drive(1, 8, 32'h0000_0004, 0, 0, 0, 0); check_pin("R4", 8);
        drive(1, 8, 32'h0000_0010, 0, 0, 0, 0); check_pin("R4", 8);
        drive(1, 8, 32'h0000_0020, 0, 0, 0, 0); check_pin("R4", 8);
        drive(1, 8, 32'h0000_0040, 0, 0, 0, 0); check_pin("R4", 8);
        // R5: mux codes 0, 1 and 7
        drive(1, 10, 32'h0000_0000, 0, 0, 0, 0); check_pin("R5", 10);
        drive(1, 10, 32'h0000_0100, 0, 0, 0, 0); check_pin("R5", 10);
        drive(1, 10, 32'h0000_0700, 0, 0, 0, 0); check_pin("R5", 10);
        // R6 / R7: group writes, others untouched
        drive(1, 0, 32'h000A_0000, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 32'h00A5_0123, 0, 0);
        check_all("R6");
        drive(0, 0, 0, 0, 0, 1, 32'h8001_0655);
        check_all("R7");
        // R8: lock, then try to clear and overwrite through both paths
        drive(1, 5, 32'h0000_8102, 0, 0, 0, 0);
        drive(1, 5, 32'h0000_0000, 0, 0, 0, 0);
        check_pin("R8", 5);
        drive(0, 0, 0, 1, 32'hFFFF_0777, 0, 0);
        check_pin("R8", 5);
        // R9: upper field of a locked pin still writable
        drive(1, 5, 32'h000C_0000, 0, 0, 0, 0);
        check_pin("R9", 5);
        // R10: bus and group on same unlocked pin in one cycle
        drive(1, 9, 32'h0000_0233, 1, 32'h0200_0474, 0, 0);
        check_pin("R10", 9);
        // R8 with both paths at once on a locked pin
        drive(1, 5, 32'h0003_0000, 1, 32'h0020_0001, 0, 0);
        check_pin("R8", 5);

        // random mix, rare locks
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] pd = $urandom;
            logic [31:0] ld = $urandom;
            logic [31:0] hd = $urandom;
            if (($urandom % 16) != 0) pd[15] = 1'b0;
            if (($urandom % 16) != 0) ld[15] = 1'b0;
            if (($urandom % 16) != 0) hd[15] = 1'b0;
            drive(1'($urandom), int'($urandom % N), pd,
                  1'($urandom), ld, 1'($urandom), hd);
            check_pin("R10", int'($urandom % N));
            if ((k % 500) == 499) check_all("R6");
        end
        check_all("R7");

        // only reset releases locks
        do_reset();
        check_all("R8");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule